// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Adaptive Dead Time

This block sequences the two gate enables of one half-bridge, one for the upper transistor and one for the lower. A two-bit phase request asks for the switch node to be pulled high, pulled low or left floating. The sequencer does not insert a fixed dead time. Before it turns a transistor on, it waits until the gate-voltage comparator of the other transistor shows that gate discharged. A programmable digital delay can be added after that confirmation.

Every gate transition opens a drive window whose length is programmable. For the length of the window the switching gate gets the strong drive current, and the gate that stays off gets a strong pulldown. After the window the driver drops to a weak hold current. At the end of each window the gate's comparator is checked against the commanded level. A mismatch latches a fault for that gate, and the fault shuts the phase down until it is cleared. An independent mode bypasses the handshake so that each gate follows its own request bit.

Top module: `hb_gate_sequencer`

## Requirements
- R1: With `indep_mode` low, `phase_cmd` = 2'b01 requests the upper gate on, 2'b10 requests the lower gate on, and 2'b00 or 2'b11 requests both gates off. During reset every output is low.
- R2: With `indep_mode` low, a gate is enabled on the first clock edge at which the comparator of the opposite gate is sampled low, provided no extra dead time is selected. As long as that comparator stays high, the gate stays off.
- R3: When `dead_sel` is nonzero, the turn-on is delayed by a further `dead_sel`*DT_STEP cycles after the handshake.
- R4: Each change of a gate enable starts a drive window of WIN_BASE<<`win_sel` cycles. The window starts on the same clock edge as the change. During the window the strong output of that gate (`strong_hi` or `strong_lo`) is high.
- R5: During a window that belongs to one gate, the pulldown output of the other gate is high while that other gate is off.
- R6: At the end of a window, if the comparator of the gate does not match that gate's enable level, the fault flag of that gate is set. The flag stays set until a `flt_clr` pulse clears it.
- R7: While either fault flag is set, both gate enables go low on the next clock edge and stay low, whatever the request.
- R8: A gate change during an active window restarts the window at full length. The comparator is not checked for the window that was cut short.
- R9: With `indep_mode` high, the upper gate follows `phase_cmd[0]` and the lower gate follows `phase_cmd[1]` on the next edge, with no handshake. If both gates change on the same edge, the window belongs to the upper gate.
- R10: A request that removes a gate drops that gate on the first clock edge after the request changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| phase_cmd | input | 2 | Requested phase state, or per-gate requests in independent mode |
| indep_mode | input | 1 | Bypasses the handshake; each gate follows its own request bit |
| win_sel | input | 2 | Drive window length select, WIN_BASE shifted left by this value |
| dead_sel | input | 2 | Extra dead time select, this value times DT_STEP cycles |
| mon_hi | input | 1 | Upper gate-voltage comparator, high when the gate is charged |
| mon_lo | input | 1 | Lower gate-voltage comparator, high when the gate is charged |
| flt_clr | input | 1 | Clears both fault flags |
| gate_hi | output | 1 | Upper gate enable |
| gate_lo | output | 1 | Lower gate enable |
| strong_hi | output | 1 | Strong drive current on the upper gate |
| strong_lo | output | 1 | Strong drive current on the lower gate |
| pd_hi | output | 1 | Strong pulldown on the upper gate |
| pd_lo | output | 1 | Strong pulldown on the lower gate |
| flt_hi | output | 1 | Sticky fault on the upper gate |
| flt_lo | output | 1 | Sticky fault on the lower gate |

## Verification
The comparator model follows each gate with a fixed delay. Because of that, the hardest situation to reach is a comparator that disagrees with its gate at the moment a window ends, or during a handshake. The bench can freeze either comparator at a chosen level. To test the fault, it holds the upper comparator low through a full window. To test R8, it holds the same comparator low through a window that a new command cuts short, and checks that no fault appears. To test the blocked handshake, it holds the lower comparator high. Before each frozen-comparator test the bench lets every earlier window run out, so that a leftover window cannot raise a stray fault.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_DT  = 2'd1,
    ST_HI  = 2'd2,
    ST_LO  = 2'd3
  } hb_state_e;

  localparam int NUM_GATES = 2;
  localparam int GATE_HI   = 0;
  localparam int GATE_LO   = 1;
endpackage

// File: rtl/hb_countdown.sv
module hb_countdown #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         busy,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = len - W'(1);
    end else if (busy) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else begin
      busy  <= busy_d;
      cnt_q <= cnt_d;
    end
  end

  assign expire = busy & (cnt_q == '0);

  // R4
  load_opens_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
endmodule

// File: rtl/hb_handshake_fsm.sv
module hb_handshake_fsm
  import hb_seq_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cmd,
  input  logic            indep,
  input  logic            mon_hi,
  input  logic            mon_lo,
  input  logic [DT_W-1:0] dt_len,
  input  logic            halt,
  output logic            nxt_hi,
  output logic            nxt_lo,
  output logic            gate_hi,
  output logic            gate_lo
);
  hb_state_e       st_q, st_d;
  logic [DT_W-1:0] dt_q, dt_d;
  logic            pend_hi_q, pend_hi_d;
  logic            req_hi, req_lo, opp_clear;
  logic            armed_q;

  assign req_hi    = (cmd == 2'b01);
  assign req_lo    = (cmd == 2'b10);
  assign opp_clear = req_hi ? ~mon_lo : ~mon_hi;

  always_comb begin
    st_d      = st_q;
    dt_d      = dt_q;
    pend_hi_d = pend_hi_q;
    nxt_hi    = 1'b0;
    nxt_lo    = 1'b0;
    if (halt) begin
      st_d = ST_OFF;
    end else if (indep) begin
      st_d   = ST_OFF;
      nxt_hi = cmd[0];
      nxt_lo = cmd[1];
    end else begin
      unique case (st_q)
        ST_OFF: begin
          if ((req_hi | req_lo) && opp_clear) begin
            pend_hi_d = req_hi;
            if (dt_len == '0) begin
              st_d = req_hi ? ST_HI : ST_LO;
            end else begin
              st_d = ST_DT;
              dt_d = dt_len - DT_W'(1);
            end
          end
        end
        ST_DT: begin
          if (!(req_hi | req_lo) || (req_hi != pend_hi_q) || !opp_clear)
            st_d = ST_OFF;
          else if (dt_q == '0)
            st_d = pend_hi_q ? ST_HI : ST_LO;
          else
            dt_d = dt_q - DT_W'(1);
        end
        ST_HI:   if (!req_hi) st_d = ST_OFF;
        ST_LO:   if (!req_lo) st_d = ST_OFF;
        default: st_d = ST_OFF;
      endcase
      nxt_hi = (st_d == ST_HI);
      nxt_lo = (st_d == ST_LO);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_OFF;
      dt_q      <= '0;
      pend_hi_q <= 1'b0;
      gate_hi   <= 1'b0;
      gate_lo   <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      st_q      <= st_d;
      dt_q      <= dt_d;
      pend_hi_q <= pend_hi_d;
      gate_hi   <= nxt_hi;
      gate_lo   <= nxt_lo;
      armed_q   <= 1'b1;
    end
  end

  // R2
  hi_waits_for_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $rose(gate_hi) && !$past(indep) |-> !$past(mon_lo));

  // R2
  lo_waits_for_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $rose(gate_lo) && !$past(indep) |-> !$past(mon_hi));

  // R7
  fault_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !gate_hi && !gate_lo);

  // R9
  indep_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(indep) && !$past(halt) |->
      gate_hi == $past(cmd[0]) && gate_lo == $past(cmd[1]));
endmodule

// File: rtl/hb_gate_fault.sv
module hb_gate_fault
  import hb_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chk,
  input  logic                 chk_lo,
  input  logic                 exp_lvl,
  input  logic [NUM_GATES-1:0] mon,
  input  logic                 clr,
  output logic [NUM_GATES-1:0] flt
);
  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    logic set_g;
    assign set_g = chk & (chk_lo == 1'(g)) & (mon[g] != exp_lvl);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flt[g] <= 1'b0;
      else if (set_g | clr)      flt[g] <= set_g;
    end

    // R6
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt[g]) |-> $past(chk) && ($past(mon[g]) != $past(exp_lvl)));
  end
endmodule

// File: rtl/hb_gate_sequencer.sv
module hb_gate_sequencer
  import hb_seq_pkg::*;
#(
  parameter int WIN_BASE = 500,
  parameter int DT_STEP  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] phase_cmd,
  input  logic       indep_mode,
  input  logic [1:0] win_sel,
  input  logic [1:0] dead_sel,
  input  logic       mon_hi,
  input  logic       mon_lo,
  input  logic       flt_clr,
  output logic       gate_hi,
  output logic       gate_lo,
  output logic       strong_hi,
  output logic       strong_lo,
  output logic       pd_hi,
  output logic       pd_lo,
  output logic       flt_hi,
  output logic       flt_lo
);
  localparam int WIN_W = $clog2(WIN_BASE * 8 + 1);
  localparam int DT_W  = $clog2(DT_STEP * 3 + 1);

  logic [1:0]           rst_sync_q;
  logic                 rst_q;
  logic [WIN_W-1:0]     win_len;
  logic [DT_W-1:0]      dt_len;
  logic                 nxt_hi, nxt_lo;
  logic                 start_hi, start_lo, win_load;
  logic                 win_busy, win_expire;
  logic                 win_lo_q, win_exp_q;
  logic [NUM_GATES-1:0] flt_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  assign win_len = WIN_W'(WIN_BASE) << win_sel;
  assign dt_len  = DT_W'(DT_STEP) * DT_W'(dead_sel);

  hb_handshake_fsm #(.DT_W(DT_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_q),
    .cmd     (phase_cmd),
    .indep   (indep_mode),
    .mon_hi  (mon_hi),
    .mon_lo  (mon_lo),
    .dt_len  (dt_len),
    .halt    (|flt_vec),
    .nxt_hi  (nxt_hi),
    .nxt_lo  (nxt_lo),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo)
  );

  assign start_hi = nxt_hi ^ gate_hi;
  assign start_lo = (nxt_lo ^ gate_lo) & ~start_hi;
  assign win_load = start_hi | start_lo;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      win_lo_q  <= 1'b0;
      win_exp_q <= 1'b0;
    end else if (win_load) begin
      win_lo_q  <= start_lo;
      win_exp_q <= start_hi ? nxt_hi : nxt_lo;
    end
  end

  hb_countdown #(.W(WIN_W)) u_win (
    .clk    (clk),
    .rst_n  (rst_q),
    .load   (win_load),
    .len    (win_len),
    .busy   (win_busy),
    .expire (win_expire)
  );

  hb_gate_fault u_flt (
    .clk     (clk),
    .rst_n   (rst_q),
    .chk     (win_expire & ~win_load),
    .chk_lo  (win_lo_q),
    .exp_lvl (win_exp_q),
    .mon     ({mon_lo, mon_hi}),
    .clr     (flt_clr),
    .flt     (flt_vec)
  );

  assign strong_hi = win_busy & ~win_lo_q;
  assign strong_lo = win_busy &  win_lo_q;
  assign pd_lo     = win_busy & ~win_lo_q & ~gate_lo;
  assign pd_hi     = win_busy &  win_lo_q & ~gate_hi;
  assign flt_hi    = flt_vec[GATE_HI];
  assign flt_lo    = flt_vec[GATE_LO];

  // R4
  hi_change_strong_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($rose(gate_hi) || $fell(gate_hi)) |-> strong_hi);

  // R4
  lo_change_strong_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($rose(gate_lo) || $fell(gate_lo)) && $stable(gate_hi) |-> strong_lo);
endmodule

// File: tb/hb_gate_sequencer_tb.sv
module hb_gate_sequencer_tb;
  localparam int WIN_BASE = 500;
  localparam int DT_STEP  = 4;
  localparam int MON_DLY  = 2;

  // {indep_mode, phase_cmd[1:0], expected gate_hi, expected gate_lo}
  localparam logic [4:0] VEC [12] = '{
    5'b0_01_1_0, 5'b0_10_0_1, 5'b0_11_0_0, 5'b0_01_1_0,
    5'b0_00_0_0, 5'b0_10_0_1, 5'b0_00_0_0, 5'b1_01_1_0,
    5'b1_11_1_1, 5'b1_10_0_1, 5'b1_00_0_0, 5'b0_00_0_0
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] phase_cmd, win_sel, dead_sel;
  logic indep_mode, flt_clr;
  logic mon_hi, mon_lo;
  logic gate_hi, gate_lo, strong_hi, strong_lo, pd_hi, pd_lo, flt_hi, flt_lo;
  logic [MON_DLY-1:0] pipe_hi, pipe_lo;
  logic stk_hi_en = 1'b0, stk_hi_v = 1'b0, stk_lo_en = 1'b0, stk_lo_v = 1'b0;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hb_gate_sequencer #(.WIN_BASE(WIN_BASE), .DT_STEP(DT_STEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .phase_cmd(phase_cmd), .indep_mode(indep_mode),
    .win_sel(win_sel), .dead_sel(dead_sel), .mon_hi(mon_hi), .mon_lo(mon_lo),
    .flt_clr(flt_clr), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .strong_hi(strong_hi), .strong_lo(strong_lo), .pd_hi(pd_hi), .pd_lo(pd_lo),
    .flt_hi(flt_hi), .flt_lo(flt_lo)
  );

  // comparator model: delayed copy of each gate, optionally frozen
  always @(negedge clk) begin
    pipe_hi <= {pipe_hi[MON_DLY-2:0], gate_hi};
    pipe_lo <= {pipe_lo[MON_DLY-2:0], gate_lo};
  end
  assign mon_hi = stk_hi_en ? stk_hi_v : pipe_hi[MON_DLY-1];
  assign mon_lo = stk_lo_en ? stk_lo_v : pipe_lo[MON_DLY-1];

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; phase_cmd = 2'b00; indep_mode = 1'b0;
    win_sel = 2'd0; dead_sel = 2'd0; flt_clr = 1'b0;
    cyc(4);
    // R1 reset state of every output
    check("R1 reset outputs",
          int'({gate_hi, gate_lo, strong_hi, strong_lo, pd_hi, pd_lo, flt_hi, flt_lo}), 0);
    rst_n = 1'b1;
    cyc(4);

    // vector table: R1 in handshake mode, R9 in independent mode
    for (int i = 0; i < 12; i++) begin
      indep_mode = VEC[i][4];
      phase_cmd  = VEC[i][3:2];
      cyc(20);
      check(VEC[i][4] ? "R9 table gate_hi" : "R1 table gate_hi", int'(gate_hi), int'(VEC[i][1]));
      check(VEC[i][4] ? "R9 table gate_lo" : "R1 table gate_lo", int'(gate_lo), int'(VEC[i][0]));
    end
    phase_cmd = 2'b00; indep_mode = 1'b0;
    cyc(5000);

    // R4 window length and R5 pulldown during a lower turn-on
    win_sel = 2'd0;
    phase_cmd = 2'b10;
    cyc(1);
    check("R4 strong_lo at turn-on", int'(strong_lo), 1);
    check("R5 pd_hi during lower window", int'(pd_hi), 1);
    check("R5 pd_lo idle", int'(pd_lo), 0);
    n = 0;
    while (strong_lo && n < 10000) begin n++; cyc(1); end
    check("R4 window length sel0", n, WIN_BASE);

    // R10 immediate turn-off, R2 handshake delay
    dead_sel = 2'd0;
    phase_cmd = 2'b01;
    cyc(1);
    check("R10 gate_lo dropped", int'(gate_lo), 0);
    check("R2 gate_hi waits", int'(gate_hi), 0);
    n = 1;
    while (!gate_hi && n < 100) begin cyc(1); n++; end
    check("R2 handshake delay", n, 1 + MON_DLY);
    check("R5 pd_lo during upper window", int'(pd_lo), 1);
    cyc(600);

    // R3 extra dead time
    dead_sel = 2'd2;
    phase_cmd = 2'b10;
    cyc(1);
    n = 1;
    while (!gate_lo && n < 100) begin cyc(1); n++; end
    check("R3 extra dead time", n, 1 + MON_DLY + 2 * DT_STEP);
    dead_sel = 2'd0;
    phase_cmd = 2'b00;
    cyc(600);

    // R2 blocked while the opposite comparator stays high
    stk_lo_v = 1'b1; stk_lo_en = 1'b1;
    phase_cmd = 2'b01;
    cyc(40);
    check("R2 blocked by mon_lo", int'(gate_hi), 0);
    stk_lo_en = 1'b0;
    cyc(1);
    check("R2 released", int'(gate_hi), 1);
    cyc(600);
    phase_cmd = 2'b00;
    cyc(600);

    // R8 restart of the window; the aborted window is not checked
    win_sel = 2'd1;
    stk_hi_v = 1'b0; stk_hi_en = 1'b1;
    phase_cmd = 2'b01;
    cyc(100);
    check("R8 gate_hi on", int'(gate_hi), 1);
    phase_cmd = 2'b00;
    cyc(1);
    n = 0;
    while (strong_hi && n < 5000) begin n++; cyc(1); end
    check("R8 restarted window length", n, 2 * WIN_BASE);
    cyc(5);
    check("R8 no fault from aborted window", int'(flt_hi), 0);

    // R6 fault on a stuck upper comparator, R7 forced shutdown
    win_sel = 2'd0;
    phase_cmd = 2'b01;
    cyc(1);
    check("R6 gate_hi on before fault", int'(gate_hi), 1);
    n = 0;
    while (strong_hi && n < 5000) begin n++; cyc(1); end
    check("R6 fault set at window end", int'(flt_hi), 1);
    check("R6 no fault on lower gate", int'(flt_lo), 0);
    cyc(1);
    check("R7 forced off", int'(gate_hi), 0);
    cyc(50);
    check("R7 held off", int'(gate_hi), 0);
    check("R6 sticky", int'(flt_hi), 1);
    phase_cmd = 2'b00;
    stk_hi_en = 1'b0;
    cyc(600);
    flt_clr = 1'b1;
    cyc(1);
    flt_clr = 1'b0;
    check("R6 cleared", int'(flt_hi), 0);
    phase_cmd = 2'b01;
    cyc(1);
    check("R6 recovers after clear", int'(gate_hi), 1);
    phase_cmd = 2'b00;
    cyc(600);

    // R9 independent mode, both gates switching together
    indep_mode = 1'b1;
    phase_cmd = 2'b11;
    cyc(1);
    check("R9 both on gate_hi", int'(gate_hi), 1);
    check("R9 both on gate_lo", int'(gate_lo), 1);
    check("R9 window to upper gate", int'(strong_hi), 1);
    check("R9 no lower window", int'(strong_lo), 0);
    phase_cmd = 2'b01;
    cyc(1);
    check("R9 lower follows cmd", int'(gate_lo), 0);
    check("R9 upper follows cmd", int'(gate_hi), 1);
    phase_cmd = 2'b00;
    indep_mode = 1'b0;
    cyc(10);

    finish_run();
  end
endmodule